// File: doc/BRIEF.md
# Eight-Line Priority Interrupt Controller

This block gathers eight interrupt request lines and tells a processor which one needs attention. It keeps a pending register, an in-service register and a mask register. It raises a single interrupt output when an unmasked pending line outranks everything already in service. When the processor answers with an acknowledge, the block hands back a vector byte. The vector combines a programmed base with the number of the winning line. The winning line then moves from pending to in-service. Line 0 ranks highest and line 7 lowest.

Software sets the block up through a byte-wide write port. A select bit chooses between the command register and the data register. A command byte with bit 4 set starts a four-byte setup sequence. That first byte is followed by three data bytes, and the first of those carries the vector base. Once setup is done, data writes load the mask, and the command byte 0x20 retires the most urgent in-service line. A flag in the first setup byte declares that line 2 is fed by a secondary controller. In that case an acknowledge of line 2 is passed to the secondary controller instead of being answered with a vector.

Top module: `irq_ctrl8`

## Requirements
- R1: After reset the controller is unconfigured. `int_out` and `vec_out` are 0 and `mask_rd` reads 0xFF. Data-port writes and request lines have no effect until a setup sequence starts.
- R2: A command write with bit 4 set starts setup. Its bit 1 set to 0 selects cascade mode and set to 1 selects single mode. The next three data writes complete setup. The first of them supplies the base, of which only bits 7:3 are kept. After the third, the controller runs with the mask, pending and in-service registers all cleared.
- R3: From the start of setup until it completes, `int_out` stays 0 and `mask_rd` reads 0xFF whatever the request lines do.
- R4: While running, a data write loads the mask, and `mask_rd` returns it. A set mask bit stops its line from raising `int_out`, but the line stays pending and raises `int_out` once it is unmasked.
- R5: A request line sampled high at a clock edge sets its pending bit at that edge. `int_out` is high while the highest-priority unmasked pending line outranks every in-service line. Line 0 ranks highest.
- R6: An `ack` while `int_out` is high drives `vec_out` in that same cycle to {base[7:3], line[2:0]}. At the next edge the line's pending bit clears and its in-service bit sets. An `ack` while `int_out` is low gives `vec_out` = 0 and changes nothing.
- R7: While a line is in service, lines of equal or lower priority cannot raise `int_out`. A higher-priority line still can, which nests interrupts.
- R8: While running, the command byte 0x20 clears the highest-priority in-service bit. Any other command byte with bit 4 clear is ignored.
- R9: In cascade mode, an acknowledged line 2 raises `sec_ack` and gives `vec_out` = 0. In single mode, line 2 is answered with a vector like any other line and `sec_ack` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 8 | Request lines, bit n is line n |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_sel | input | 1 | 0 selects the command register, 1 selects the data register |
| wr_data | input | 8 | Write data byte |
| ack | input | 1 | Processor acknowledge |
| int_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector byte, valid in the acknowledged cycle |
| sec_ack | output | 1 | Acknowledge passed to the secondary controller for line 2 |
| mask_rd | output | 8 | Mask readback |

## Verification
The assertions assume that every input is a known binary value at each rising edge. The in-service counting checks also assume that no EOI and no setup restart arrive in the same cycle as an acknowledge, so those antecedents exclude such cycles. The bench changes inputs only on the falling edge and keeps them at 0 or 1. Its random mix sends request pulses, acknowledges, mask writes, EOIs, ignored command bytes and occasional re-setup sequences, so all orderings are exercised, including an EOI together with an acknowledge.

// File: rtl/irq8_pkg.sv
// Shared definitions for the eight-line interrupt controller.
// Assumes the command byte encodings below are fixed by the software interface.
package irq8_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_W2   = 3'd1,
        ST_W3   = 3'd2,
        ST_W4   = 3'd3,
        ST_RUN  = 3'd4
    } init_st_t;

    localparam logic [7:0] EOI_CODE  = 8'h20;
    localparam int         START_BIT = 4;
    localparam int         SNGL_BIT  = 1;
endpackage

// File: rtl/irq8_prio_pick.sv
// Finds the lowest-numbered set bit of a vector (index 0 ranks highest).
// Assumes nothing about the input; idx is 0 when none is set.
module irq8_prio_pick #(
    parameter int N = 8,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx
);
    // Scan from the lowest rank upward so the highest-priority set bit wins.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irq8_init_seq.sv
// Setup sequencer: tracks the four-byte setup and holds the base, cascade flag and mask.
// Assumes one write per cycle; a start byte on the command port always restarts setup.
module irq8_init_seq
    import irq8_pkg::*;
#(
    parameter int N     = 8,
    parameter int VEC_W = 8,
    localparam int LW   = $clog2(N)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_sel,
    input  logic [VEC_W-1:0]   wr_data,
    output logic               run,
    output logic               restart,
    output logic               casc_en,
    output logic [VEC_W-LW-1:0] base_hi,
    output logic [N-1:0]       mask
);
    init_st_t st_q;

    // A command byte with the start bit set begins a new setup.
    assign restart = wr_en && !wr_sel && wr_data[START_BIT];
    assign run     = (st_q == ST_RUN);

    // Step through the setup bytes, then route data writes to the mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            base_hi <= '0;
            casc_en <= 1'b0;
            mask    <= '0;
        end else if (restart) begin
            st_q    <= ST_W2;
            casc_en <= !wr_data[SNGL_BIT];
            mask    <= '0;
        end else if (wr_en && wr_sel) begin
            case (st_q)
                ST_W2: begin
                    base_hi <= wr_data[VEC_W-1:LW];
                    st_q    <= ST_W3;
                end
                ST_W3:   st_q <= ST_W4;
                ST_W4:   st_q <= ST_RUN;
                ST_RUN:  mask <= wr_data[N-1:0];
                default: st_q <= st_q;
            endcase
        end
    end
endmodule

// File: rtl/irq8_core.sv
// Pending and in-service registers with fixed-priority arbitration.
// Assumes eoi only arrives while running; pending is held clear outside run.
module irq8_core #(
    parameter int N    = 8,
    localparam int LW  = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  irq_in,
    input  logic          run,
    input  logic          restart,
    input  logic [N-1:0]  mask,
    input  logic          ack,
    input  logic          eoi,
    output logic          int_out,
    output logic          take,
    output logic [LW-1:0] win_idx,
    output logic [N-1:0]  pend,
    output logic [N-1:0]  serv
);
    logic [N-1:0]  cand;
    logic          c_any, s_any;
    logic [LW-1:0] s_idx;
    logic [N-1:0]  win_oh, top_oh;

    assign cand = pend & ~mask;

    irq8_prio_pick #(.N(N)) i_pick_cand (.vec(cand), .any(c_any), .idx(win_idx));
    irq8_prio_pick #(.N(N)) i_pick_serv (.vec(serv), .any(s_any), .idx(s_idx));

    // Request goes out only when the best candidate outranks all lines in service.
    assign int_out = run && c_any && (!s_any || (win_idx < s_idx));
    assign take    = ack && int_out;
    assign win_oh  = take ? (N'(1) << win_idx) : '0;
    assign top_oh  = (eoi && s_any) ? (N'(1) << s_idx) : '0;

    // Latch request lines; the acknowledged line leaves the pending set.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart) begin
            pend <= '0;
        end else begin
            pend <= (pend | irq_in) & ~win_oh;
        end
    end

    // Track lines being serviced; EOI retires the most urgent one.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            serv <= '0;
        end else begin
            serv <= (serv & ~top_oh) | win_oh;
        end
    end
endmodule

// File: rtl/irq_ctrl8.sv
// Top of the eight-line interrupt controller: write decode, vector build, cascade hand-off.
// Assumes the secondary controller on line 2 drives its own vector when sec_ack is high.
module irq_ctrl8
    import irq8_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int VEC_W     = 8,
    parameter int CASC_LINE = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 wr_en,
    input  logic                 wr_sel,
    input  logic [VEC_W-1:0]     wr_data,
    input  logic                 ack,
    output logic                 int_out,
    output logic [VEC_W-1:0]     vec_out,
    output logic                 sec_ack,
    output logic [NUM_LINES-1:0] mask_rd
);
    localparam int LW = $clog2(NUM_LINES);

    logic                  run, restart, casc_en, eoi, take;
    logic [VEC_W-LW-1:0]   base_hi;
    logic [NUM_LINES-1:0]  mask, pend, serv;
    logic [LW-1:0]         win_idx;

    irq8_init_seq #(.N(NUM_LINES), .VEC_W(VEC_W)) i_init (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .run(run), .restart(restart), .casc_en(casc_en), .base_hi(base_hi), .mask(mask)
    );

    // End of interrupt is only honoured once setup is complete.
    assign eoi = run && wr_en && !wr_sel && (wr_data == EOI_CODE);

    irq8_core #(.N(NUM_LINES)) i_core (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .run(run), .restart(restart),
        .mask(mask), .ack(ack), .eoi(eoi), .int_out(int_out), .take(take),
        .win_idx(win_idx), .pend(pend), .serv(serv)
    );

    // Hand line CASC_LINE to the secondary controller in cascade mode, else build the vector.
    always_comb begin
        sec_ack = take && casc_en && (win_idx == LW'(CASC_LINE));
        if (take && !sec_ack) vec_out = {base_hi, win_idx};
        else                  vec_out = '0;
    end

    assign mask_rd = run ? mask : '1;
endmodule

// File: rtl/irq_ctrl8_chk.sv
// Property checker for irq_ctrl8, attached by bind; observes ports and internal registers.
// Assumes known inputs at every rising edge.
module irq_ctrl8_chk #(
    parameter int N     = 8,
    parameter int VEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             int_out,
    input logic             ack,
    input logic             sec_ack,
    input logic [VEC_W-1:0] vec_out,
    input logic             wr_en,
    input logic             wr_sel,
    input logic [VEC_W-1:0] wr_data,
    input logic [N-1:0]     mask_rd,
    input logic             run,
    input logic [N-1:0]     pend,
    input logic [N-1:0]     serv
);
    AST_SETUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!int_out && mask_rd == '1)); // R3

    AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> ((pend & ~mask_rd) != '0)); // R4

    AST_ACK_ENTERS_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && int_out && !wr_en) |=> ($countones(serv) == $countones($past(serv)) + 1)); // R6

    AST_IDLE_ACK_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !int_out && !wr_en) |-> (vec_out == '0 && !sec_ack)); // R6

    AST_EOI_RETIRES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && wr_en && !wr_sel && wr_data == 8'h20 && serv != '0 && !ack)
        |=> ($countones(serv) + 1 == $countones($past(serv)))); // R8

    AST_SEC_ACK_NO_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        sec_ack |-> (ack && vec_out == '0)); // R9
endmodule

bind irq_ctrl8 irq_ctrl8_chk #(.N(NUM_LINES), .VEC_W(VEC_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .int_out(int_out), .ack(ack), .sec_ack(sec_ack),
    .vec_out(vec_out), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .mask_rd(mask_rd), .run(run), .pend(pend), .serv(serv)
);

// File: tb/test_irq_ctrl8.sv
`timescale 1ns/1ps
module test_irq_ctrl8;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_in = '0;
    logic       wr_en = 1'b0, wr_sel = 1'b0, ack = 1'b0;
    logic [7:0] wr_data = '0;
    logic       int_out, sec_ack;
    logic [7:0] vec_out, mask_rd;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // Reference state kept from the requirements.
    int       m_st = 0;            // 0 idle, 1..3 setup bytes expected, 4 running
    bit       m_casc = 0;
    bit [7:0] m_base = 0, m_mask = 0, m_pend = 0, m_serv = 0;

    irq_ctrl8 i_irq_ctrl8 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .ack(ack), .int_out(int_out), .vec_out(vec_out),
        .sec_ack(sec_ack), .mask_rd(mask_rd)
    );

    always #2 clk = ~clk;

    function automatic int lowest(input bit [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return 8;
    endfunction

    function automatic bit exp_int();
        bit [7:0] c = m_pend & ~m_mask;
        return (m_st == 4) && (c != 0) && (lowest(c) < lowest(m_serv));
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        finished = 1;
        $finish;
    endtask

    // One cycle: drive after the falling edge, compare outputs, then update the model at the rising edge.
    task automatic step(input bit [7:0] irq, input bit a, input bit we, input bit sel,
                        input bit [7:0] d, input string tag);
        bit e_int, e_sec, take;
        bit [7:0] e_vec, np, ns;
        int w;
        irq_in = irq; ack = a; wr_en = we; wr_sel = sel; wr_data = d;
        #1;
        e_int = exp_int();
        w     = lowest(m_pend & ~m_mask);
        take  = a && e_int;
        e_sec = take && m_casc && (w == 2);
        e_vec = (take && !e_sec) ? ((m_base & 8'hF8) | 8'(w)) : 8'h00;
        check(tag, "int_out", int_out, e_int);
        check(tag, "vec_out", vec_out, e_vec);
        check(tag, "sec_ack", sec_ack, e_sec);
        check(tag, "mask_rd", mask_rd, (m_st == 4) ? m_mask : 8'hFF);
        @(posedge clk);
        np = 0;
        ns = m_serv;
        if (m_st == 4) begin
            np = m_pend | irq;
            if (we && !sel && d == 8'h20 && m_serv != 0) ns[lowest(m_serv)] = 1'b0;
            if (take) begin
                np[w] = 1'b0;
                ns[w] = 1'b1;
            end
        end
        if (we && !sel && d[4]) begin
            m_st = 1; m_casc = !d[1]; m_mask = 0; np = 0; ns = 0;
        end else if (we && sel) begin
            case (m_st)
                1: begin m_base = d & 8'hF8; m_st = 2; end
                2: m_st = 3;
                3: m_st = 4;
                4: m_mask = d;
                default: ;
            endcase
        end
        m_pend = np;
        m_serv = ns;
        @(negedge clk);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(8'h00, 0, 0, 0, 8'h00, tag);
    endtask

    task automatic setup(input bit [7:0] c1, input bit [7:0] base, input string tag);
        step(8'h00, 0, 1, 0, c1, tag);
        step(8'hFF, 0, 1, 1, base, tag);
        step(8'h04, 1, 1, 1, 8'h00, tag);
        step(8'h00, 0, 1, 1, 8'h01, tag);
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: unconfigured after reset; data writes and requests do nothing.
        step(8'h00, 0, 0, 0, 8'h00, "R1");
        step(8'h01, 1, 1, 1, 8'h00, "R1");
        idle(2, "R1");
        // R2 and R3: single mode, base 0x48; outputs quiet during setup.
        setup(8'h13, 8'h4F, "R3");
        idle(1, "R2");
        // R5 and R6: line 3 alone.
        step(8'h08, 0, 0, 0, 8'h00, "R5");
        step(8'h00, 1, 0, 0, 8'h00, "R6");
        idle(1, "R6");
        // R7: line 5 held off by 3 in service; line 1 nests.
        step(8'h20, 0, 0, 0, 8'h00, "R7");
        idle(1, "R7");
        step(8'h02, 0, 0, 0, 8'h00, "R7");
        step(8'h00, 1, 0, 0, 8'h00, "R7");
        // R8: ignored command, then EOIs retire 1 then 3, releasing line 5.
        step(8'h00, 0, 1, 0, 8'h0A, "R8");
        step(8'h00, 0, 1, 0, 8'h20, "R8");
        step(8'h00, 0, 1, 0, 8'h20, "R8");
        step(8'h00, 1, 0, 0, 8'h00, "R8");
        step(8'h00, 0, 1, 0, 8'h20, "R8");
        // R4: mask line 3, request it, unmask.
        step(8'h00, 0, 1, 1, 8'h08, "R4");
        step(8'h08, 0, 0, 0, 8'h00, "R4");
        idle(1, "R4");
        step(8'h00, 0, 1, 1, 8'h00, "R4");
        step(8'h00, 1, 0, 0, 8'h00, "R4");
        step(8'h00, 0, 1, 0, 8'h20, "R4");
        // R6: acknowledge with nothing pending.
        step(8'h00, 1, 0, 0, 8'h00, "R6");
        // R9: cascade mode, base 0x20.
        setup(8'h11, 8'h20, "R9");
        step(8'h14, 0, 0, 0, 8'h00, "R9");
        step(8'h00, 1, 0, 0, 8'h00, "R9");
        step(8'h00, 0, 1, 0, 8'h20, "R9");
        step(8'h00, 1, 0, 0, 8'h00, "R9");
        step(8'h00, 0, 1, 0, 8'h20, "R9");
        // Random mix against the model.
        for (int i = 0; i < 4000; i++) begin
            bit [7:0] irq, d;
            bit a, we, sel;
            int r;
            irq = ($urandom % 5 == 0) ? 8'(1 << ($urandom % 8)) : 8'h00;
            a   = ($urandom % 3 == 0);
            r   = $urandom % 24;
            we = 1; sel = 0; d = 8'h00;
            if (r == 0)                 begin sel = 1; d = 8'($urandom & $urandom); end
            else if (r < 4)             d = 8'h20;
            else if (r == 4)            d = 8'h0A;
            else if (r == 5 && i % 500 == 0) d = ($urandom % 2) ? 8'h11 : 8'h13;
            else if (r == 6)            begin sel = 1; d = 8'($urandom); end
            else                        we = 0;
            step(irq, a, we, sel, d, "RND");
        end
        summary();
    end
endmodule